// File: doc/BRIEF.md
# Update-Based Snooping Coherence Controller

This block is the coherence engine of one write-back cache in a snooping multiprocessor that keeps copies consistent by pushing written words to the other caches rather than invalidating them. It serves processor loads and stores against a small direct-mapped array of multi-word lines. It starts bus reads on misses, word-update broadcasts on stores to shared lines, and write-backs when a dirty line is replaced. It also watches the bus for reads and updates from other caches. A line that is resident is always in one of four states: sole clean, sole dirty, shared clean or shared owner. There is no invalid state for a resident line. A line that is not resident is simply absent.

Broadcast words reach only the other caches and never memory. Among all caches at most one holds a block as shared owner, and that cache supplies the block to readers and writes it back to memory when it is replaced. A wired-OR shared input, sampled in the grant cycle of this cache's own bus transaction, tells the controller whether any other cache holds the block. The bus is atomic: the grant cycle carries the fill data and the shared result, and no snoop is presented in a cycle in which this cache is granted.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset no line is resident. `bus_req` and `cpu_done` are low, and a snoop to any address leaves `snp_copy` low.
- R2: A read miss issues a bus read (`bus_cmd`=0) at the block-aligned address (offset bits zero). It fills the line as sole clean if `bus_shared` is low in the grant cycle and as shared clean if it is high. `cpu_rdata` returns the addressed word.
- R3: A store that hits a sole clean or sole dirty line completes with no bus transaction, and the line becomes sole dirty.
- R4: A store that hits a shared clean or shared owner line issues one update (`bus_cmd`=1) carrying the word address and the word. The line becomes shared owner if `bus_shared` is high and sole dirty if it is low. No write-back (`bus_cmd`=2) is produced.
- R5: A store miss first performs the bus read of R2. If `bus_shared` was high it then issues an update and ends as shared owner. If it was low it ends sole dirty with no update.
- R6: A snooped update (`snp_cmd`=1) to a resident block raises `snp_copy`, merges the word into the line, and leaves the line shared clean, so that a later replacement is silent.
- R7: A snooped read (`snp_cmd`=0) to a resident block raises `snp_copy`. If the line is sole dirty or shared owner, `snp_supply` rises with the whole line on `snp_line`, and the line ends as shared owner. A sole clean line becomes shared clean without supplying data.
- R8: A miss whose index holds another block in sole dirty or shared owner state first writes that block back (`bus_cmd`=2, its block address, its line data) and then reads. A clean victim is dropped with no bus transaction.
- R9: A snoop whose block is not resident leaves `snp_copy` and `snp_supply` low and changes nothing.
- R10: `cpu_done` is high for exactly one cycle per request. A pending `bus_req` keeps its command and address stable until `bus_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address {tag, index, offset} |
| cpu_wdata | input | DW | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Addressed word, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 0 read, 1 word update, 2 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Update word |
| bus_line | output | WORDS*DW | Write-back line |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_fill | input | WORDS*DW | Fill line, valid with a read grant |
| bus_shared | input | 1 | Wired-OR: another cache holds the block |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 1 | 0 read, 1 update |
| snp_addr | input | AW | Snooped word address |
| snp_wdata | input | DW | Snooped update word |
| snp_copy | output | 1 | This cache holds the snooped block |
| snp_supply | output | 1 | This cache answers the snooped read |
| snp_line | output | WORDS*DW | Line supplied on a snooped read |

## Verification
Every word address of a reduced configuration is swept with loads and stores under both values of the shared input. Each access is followed by a snooped read or update to the same address and then a second store. This walks every line through all four states, both clean and dirty replacement, and every snoop reaction. The expected transaction list (write-back, read, update), the addresses, the words and the returned data come from a small per-line state model in the bench. Storing with the shared input low versus high separates a silent upgrade from a broadcast. Ending with a snoop update versus a snoop read separates a silent replacement from a write-back. A long pseudo-random mix of processor and snoop operations then exercises sequences the sweep does not order.

// File: rtl/upd_coh_pkg.sv
// Package: shared types for the update-based coherence controller.
// Assumes 2-bit state and command codes; the encodings are fixed at the ports.
package upd_coh_pkg;

    typedef enum logic [1:0] {
        LS_SOLE_CLEAN = 2'd0,
        LS_SHR_CLEAN  = 2'd1,
        LS_SHR_OWNER  = 2'd2,
        LS_SOLE_DIRTY = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        BC_READ   = 2'd0,
        BC_UPDATE = 2'd1,
        BC_WRBACK = 2'd2
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_WBACK,
        CS_FETCH,
        CS_UPD,
        CS_RESP
    } ctrl_state_e;

    localparam logic SN_READ   = 1'b0;
    localparam logic SN_UPDATE = 1'b1;

    // True for the states that carry the memory write-back duty.
    function automatic logic owns_dirty(line_state_e s);
        return (s == LS_SOLE_DIRTY) || (s == LS_SHR_OWNER);
    endfunction

endpackage

// File: rtl/upd_coh_store.sv
// Line store: presence bits, coherence states, tags and data of a
// direct-mapped array. Two read ports (processor side, snoop side) and two
// update ports; the processor-side update is applied after the snoop-side one.
// Assumes NLINES is a power of two.
module upd_coh_store
    import upd_coh_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int WORDS  = 2,
    parameter int DW     = 8,
    parameter int TAGW   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    // processor-side lookup
    input  logic [$clog2(NLINES)-1:0] a_idx,
    output logic                    a_pres,
    output line_state_e             a_state,
    output logic [TAGW-1:0]         a_tag,
    output logic [WORDS*DW-1:0]     a_line,
    // snoop-side lookup
    input  logic [$clog2(NLINES)-1:0] b_idx,
    output logic                    b_pres,
    output line_state_e             b_state,
    output logic [TAGW-1:0]         b_tag,
    output logic [WORDS*DW-1:0]     b_line,
    // snoop-side update
    input  logic                    s_st_en,
    input  line_state_e             s_state,
    input  logic                    s_merge_en,
    input  logic [$clog2(WORDS)-1:0] s_off,
    input  logic [DW-1:0]           s_word,
    // processor-side update
    input  logic                    c_fill_en,
    input  logic [TAGW-1:0]         c_tag,
    input  logic [WORDS*DW-1:0]     c_line,
    input  logic                    c_st_en,
    input  line_state_e             c_state,
    input  logic                    c_wr_en,
    input  logic [$clog2(WORDS)-1:0] c_off,
    input  logic [DW-1:0]           c_word,
    input  logic                    c_drop_en
);

    logic [NLINES-1:0] pres_q;
    line_state_e       st_q   [NLINES];
    logic [TAGW-1:0]   tag_q  [NLINES];
    logic [DW-1:0]     data_q [NLINES][WORDS];

    // Read ports: present the indexed line on both sides.
    always_comb begin
        a_pres  = pres_q[a_idx];
        a_state = st_q[a_idx];
        a_tag   = tag_q[a_idx];
        b_pres  = pres_q[b_idx];
        b_state = st_q[b_idx];
        b_tag   = tag_q[b_idx];
        for (int w = 0; w < WORDS; w++) begin
            a_line[w*DW +: DW] = data_q[a_idx][w];
            b_line[w*DW +: DW] = data_q[b_idx][w];
        end
    end

    // Presence, state and tag update; processor side overrides snoop side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= '0;
            for (int n = 0; n < NLINES; n++) begin
                st_q[n]  <= LS_SOLE_CLEAN;
                tag_q[n] <= '0;
            end
        end else begin
            if (s_st_en)   st_q[b_idx] <= s_state;
            if (c_drop_en) pres_q[a_idx] <= 1'b0;
            if (c_fill_en) begin
                pres_q[a_idx] <= 1'b1;
                tag_q[a_idx]  <= c_tag;
            end
            if (c_st_en)   st_q[a_idx] <= c_state;
        end
    end

    // Data update: snoop merge, then fill, then processor word write.
    always_ff @(posedge clk) begin
        if (s_merge_en) data_q[b_idx][s_off] <= s_word;
        if (c_fill_en) begin
            for (int w = 0; w < WORDS; w++) begin
                data_q[a_idx][w] <= c_line[w*DW +: DW];
            end
        end
        if (c_wr_en) data_q[a_idx][c_off] <= c_word;
    end

endmodule

// File: rtl/upd_coh_snoop.sv
// Snoop decoder: from the looked-up line and the snooped command, decides
// the copy and supply responses and the next state of the line. Purely
// combinational; assumes the lookup is indexed by the snooped address.
module upd_coh_snoop
    import upd_coh_pkg::*;
#(
    parameter int TAGW = 2
) (
    input  logic            snp_valid,
    input  logic            snp_cmd,
    input  logic [TAGW-1:0] snp_tag,
    input  logic            b_pres,
    input  line_state_e     b_state,
    input  logic [TAGW-1:0] b_tag,
    output logic            copy,
    output logic            supply,
    output logic            st_en,
    output line_state_e     st_next,
    output logic            merge_en
);

    logic hit;

    // Response and state transition for a snooped read or update.
    always_comb begin
        hit      = snp_valid && b_pres && (b_tag == snp_tag);
        copy     = hit;
        supply   = 1'b0;
        st_en    = hit;
        merge_en = 1'b0;
        st_next  = LS_SHR_CLEAN;
        if (hit && snp_cmd == SN_READ) begin
            supply  = owns_dirty(b_state);
            st_next = owns_dirty(b_state) ? LS_SHR_OWNER : LS_SHR_CLEAN;
        end else if (hit) begin
            merge_en = 1'b1;
        end
    end

endmodule

// File: rtl/upd_coh_fsm.sv
// Processor-side controller: accepts one request at a time, resolves hits,
// and sequences write-back, fill and update transactions on an atomic bus.
// Assumes no snoop arrives in a cycle in which this cache is granted; a
// snoop in the idle cycle defers acceptance of a new request.
module upd_coh_fsm
    import upd_coh_pkg::*;
#(
    parameter int TAGW = 2,
    parameter int IDXW = 2,
    parameter int OFFW = 1,
    parameter int DW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [TAGW+IDXW+OFFW-1:0] cpu_addr,
    input  logic [DW-1:0]            cpu_wdata,
    output logic                     cpu_done,
    input  logic                     snp_busy,
    input  logic                     lk_pres,
    input  line_state_e              lk_state,
    input  logic [TAGW-1:0]          lk_tag,
    output logic [IDXW-1:0]          cur_idx,
    output logic [TAGW-1:0]          cur_tag,
    output logic [OFFW-1:0]          cur_off,
    output logic [DW-1:0]            cur_word,
    output logic                     c_fill_en,
    output logic                     c_st_en,
    output line_state_e              c_state,
    output logic                     c_wr_en,
    output logic                     c_drop_en,
    output logic                     bus_req,
    output logic [1:0]               bus_cmd,
    output logic [TAGW+IDXW+OFFW-1:0] bus_addr,
    output logic [DW-1:0]            bus_wdata,
    input  logic                     bus_gnt,
    input  logic                     bus_shared
);

    localparam int AW = TAGW + IDXW + OFFW;

    ctrl_state_e   cs_q, cs_d;
    logic [AW-1:0] op_addr_q;
    logic          op_we_q;
    logic [DW-1:0] op_wdata_q;
    logic [AW-1:0] cur_addr;
    logic          idle, hit, accept;

    // Current operation: the incoming request while idle, else the latched one.
    always_comb begin
        idle     = (cs_q == CS_IDLE);
        cur_addr = idle ? cpu_addr : op_addr_q;
        cur_word = idle ? cpu_wdata : op_wdata_q;
        cur_tag  = cur_addr[AW-1 -: TAGW];
        cur_idx  = cur_addr[OFFW +: IDXW];
        cur_off  = cur_addr[OFFW-1:0];
        hit      = lk_pres && (lk_tag == cur_tag);
        accept   = idle && cpu_req && !snp_busy;
    end

    // Next state, bus request and line-store controls.
    always_comb begin
        cs_d      = cs_q;
        bus_req   = 1'b0;
        bus_cmd   = BC_READ;
        bus_addr  = '0;
        bus_wdata = op_wdata_q;
        cpu_done  = 1'b0;
        c_fill_en = 1'b0;
        c_st_en   = 1'b0;
        c_state   = LS_SOLE_DIRTY;
        c_wr_en   = 1'b0;
        c_drop_en = 1'b0;
        case (cs_q)
            CS_IDLE: begin
                if (accept) begin
                    if (hit && !cpu_we) begin
                        cs_d = CS_RESP;
                    end else if (hit && !(lk_state == LS_SHR_CLEAN || lk_state == LS_SHR_OWNER)) begin
                        c_wr_en = 1'b1;
                        c_st_en = 1'b1;
                        cs_d    = CS_RESP;
                    end else if (hit) begin
                        cs_d = CS_UPD;
                    end else if (lk_pres && owns_dirty(lk_state)) begin
                        cs_d = CS_WBACK;
                    end else begin
                        cs_d = CS_FETCH;
                    end
                end
            end
            CS_WBACK: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_WRBACK;
                bus_addr = {lk_tag, cur_idx, {OFFW{1'b0}}};
                if (bus_gnt) begin
                    c_drop_en = 1'b1;
                    cs_d      = CS_FETCH;
                end
            end
            CS_FETCH: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_READ;
                bus_addr = {cur_tag, cur_idx, {OFFW{1'b0}}};
                if (bus_gnt) begin
                    c_fill_en = 1'b1;
                    c_st_en   = 1'b1;
                    c_state   = bus_shared ? LS_SHR_CLEAN : LS_SOLE_CLEAN;
                    cs_d      = CS_RESP;
                    if (op_we_q && bus_shared) begin
                        cs_d = CS_UPD;
                    end else if (op_we_q) begin
                        c_wr_en = 1'b1;
                        c_state = LS_SOLE_DIRTY;
                    end
                end
            end
            CS_UPD: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_UPDATE;
                bus_addr = op_addr_q;
                if (bus_gnt) begin
                    c_wr_en = 1'b1;
                    c_st_en = 1'b1;
                    c_state = bus_shared ? LS_SHR_OWNER : LS_SOLE_DIRTY;
                    cs_d    = CS_RESP;
                end
            end
            CS_RESP: begin
                cpu_done = 1'b1;
                cs_d     = CS_IDLE;
            end
            default: cs_d = CS_IDLE;
        endcase
    end

    // Controller state register.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= CS_IDLE;
        else        cs_q <= cs_d;
    end

    // Latch the accepted request for the multi-cycle sequences.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr_q  <= '0;
            op_we_q    <= 1'b0;
            op_wdata_q <= '0;
        end else if (accept) begin
            op_addr_q  <= cpu_addr;
            op_we_q    <= cpu_we;
            op_wdata_q <= cpu_wdata;
        end
    end

endmodule

// File: rtl/upd_coh_ctrl.sv
// Top: update-based snooping coherence controller for one direct-mapped
// write-back cache. Ties the line store, the snoop decoder and the
// processor-side controller together. Assumes an atomic bus and that the
// shared wired-OR is valid in this cache's grant cycle.
module upd_coh_ctrl
    import upd_coh_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int WORDS  = 2,
    parameter int DW     = 8,
    parameter int TAGW   = 2,
    localparam int IDXW  = $clog2(NLINES),
    localparam int OFFW  = $clog2(WORDS),
    localparam int AW    = TAGW + IDXW + OFFW,
    localparam int LW    = WORDS * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic [LW-1:0] bus_line,
    input  logic          bus_gnt,
    input  logic [LW-1:0] bus_fill,
    input  logic          bus_shared,
    input  logic          snp_valid,
    input  logic          snp_cmd,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_wdata,
    output logic          snp_copy,
    output logic          snp_supply,
    output logic [LW-1:0] snp_line
);

    logic            a_pres, b_pres;
    line_state_e     a_state, b_state;
    logic [TAGW-1:0] a_tag, b_tag;
    logic [LW-1:0]   a_line;
    logic [IDXW-1:0] cur_idx;
    logic [TAGW-1:0] cur_tag;
    logic [OFFW-1:0] cur_off;
    logic [DW-1:0]   cur_word;
    logic            c_fill_en, c_st_en, c_wr_en, c_drop_en;
    line_state_e     c_state;
    logic            s_st_en, s_merge_en;
    line_state_e     s_state;

    upd_coh_store #(
        .NLINES(NLINES), .WORDS(WORDS), .DW(DW), .TAGW(TAGW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_idx      (cur_idx),
        .a_pres     (a_pres),
        .a_state    (a_state),
        .a_tag      (a_tag),
        .a_line     (a_line),
        .b_idx      (snp_addr[OFFW +: IDXW]),
        .b_pres     (b_pres),
        .b_state    (b_state),
        .b_tag      (b_tag),
        .b_line     (snp_line),
        .s_st_en    (s_st_en),
        .s_state    (s_state),
        .s_merge_en (s_merge_en),
        .s_off      (snp_addr[OFFW-1:0]),
        .s_word     (snp_wdata),
        .c_fill_en  (c_fill_en),
        .c_tag      (cur_tag),
        .c_line     (bus_fill),
        .c_st_en    (c_st_en),
        .c_state    (c_state),
        .c_wr_en    (c_wr_en),
        .c_off      (cur_off),
        .c_word     (cur_word),
        .c_drop_en  (c_drop_en)
    );

    upd_coh_snoop #(.TAGW(TAGW)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_tag   (snp_addr[AW-1 -: TAGW]),
        .b_pres    (b_pres),
        .b_state   (b_state),
        .b_tag     (b_tag),
        .copy      (snp_copy),
        .supply    (snp_supply),
        .st_en     (s_st_en),
        .st_next   (s_state),
        .merge_en  (s_merge_en)
    );

    upd_coh_fsm #(.TAGW(TAGW), .IDXW(IDXW), .OFFW(OFFW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_done   (cpu_done),
        .snp_busy   (snp_valid),
        .lk_pres    (a_pres),
        .lk_state   (a_state),
        .lk_tag     (a_tag),
        .cur_idx    (cur_idx),
        .cur_tag    (cur_tag),
        .cur_off    (cur_off),
        .cur_word   (cur_word),
        .c_fill_en  (c_fill_en),
        .c_st_en    (c_st_en),
        .c_state    (c_state),
        .c_wr_en    (c_wr_en),
        .c_drop_en  (c_drop_en),
        .bus_req    (bus_req),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_gnt    (bus_gnt),
        .bus_shared (bus_shared)
    );

    // Victim line for write-back and the addressed word for the processor.
    always_comb begin
        bus_line  = a_line;
        cpu_rdata = a_line[cur_off*DW +: DW];
    end

endmodule

// File: rtl/upd_coh_checker.sv
// Checker: temporal properties of the controller's ports, bound to the top.
module upd_coh_checker #(
    parameter int AW   = 5,
    parameter int OFFW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_done,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [1:0]    bus_cmd,
    input logic [AW-1:0] bus_addr,
    input logic          snp_valid,
    input logic          snp_cmd,
    input logic          snp_copy,
    input logic          snp_supply
);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    p_read_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd0) |-> (bus_addr[OFFW-1:0] == '0));

    p_wb_then_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd2) |=> (bus_req && bus_cmd == 2'd0));

    p_supply_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_copy && snp_valid && snp_cmd == 1'b0));

    p_quiet_without_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |-> (!snp_copy && !snp_supply));

endmodule

bind upd_coh_ctrl upd_coh_checker #(.AW(AW), .OFFW(OFFW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_done   (cpu_done),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_copy   (snp_copy),
    .snp_supply (snp_supply)
);

// File: tb/sim_upd_coh_ctrl.sv
`timescale 1ns/1ps
// Bench: sweeps every address with loads/stores under both shared values,
// interleaved with snoops, then a pseudo-random mix; a per-line model
// derived from the requirements predicts every bus transaction and datum.
module sim_upd_coh_ctrl;

    localparam int NL = 4, WD = 2, DW = 8, TW = 2;
    localparam int AW = 5, LW = 16;
    localparam int SC = 0, SH = 1, SO = 2, SD = 3; // sole clean, shared clean, owner, sole dirty

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [LW-1:0] bus_line;
    logic          bus_gnt = 1'b0, bus_shared = 1'b0;
    logic [LW-1:0] bus_fill = '0;
    logic          snp_valid = 1'b0, snp_cmd = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_wdata = '0;
    logic          snp_copy, snp_supply;
    logic [LW-1:0] snp_line;

    int total = 0, bad = 0;

    bit          mp   [NL];
    int          mst  [NL];
    int          mtag [NL];
    logic [DW-1:0] mdat [NL][WD];
    logic [DW-1:0] mem  [32];

    always #2.5 clk = ~clk;

    upd_coh_ctrl #(.NLINES(NL), .WORDS(WD), .DW(DW), .TAGW(TW)) u0 (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input logic shr);
        int t = a[4:3], i = a[2:1], o = a[0];
        bit hit = mp[i] && mtag[i] == t;
        bit e_wb = !hit && mp[i] && (mst[i] == SO || mst[i] == SD);
        bit e_upd = 1'b0;
        logic [AW-1:0] e_wba = {2'(mtag[i]), 2'(i), 1'b0};
        logic [LW-1:0] e_wbl = {mdat[i][1], mdat[i][0]};
        logic [DW-1:0] e_rd;
        string rq;
        int n_wb = 0, n_rd = 0, n_upd = 0, cyc = 0;
        logic [AW-1:0] g_wba = '0, g_rda = '0, g_upa = '0;
        logic [LW-1:0] g_wbl = '0;
        logic [DW-1:0] g_upd = '0, g_rdata = '0;
        bit got = 1'b0;
        rq = we ? (hit ? ((mst[i] == SH || mst[i] == SO) ? "R4" : "R3") : "R5") : "R2";
        if (e_wb) begin
            mem[e_wba] = mdat[i][0];
            mem[e_wba | 5'd1] = mdat[i][1];
        end
        if (!hit) begin
            mp[i] = 1; mtag[i] = t; mst[i] = shr ? SH : SC;
            mdat[i][0] = mem[{a[4:1], 1'b0}];
            mdat[i][1] = mem[{a[4:1], 1'b1}];
        end
        if (we) begin
            if (mst[i] == SC || mst[i] == SD) mst[i] = SD;
            else begin e_upd = 1'b1; mst[i] = shr ? SO : SD; end
            mdat[i][o] = wd;
        end
        e_rd = mdat[i][o];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; bus_shared = shr;
        while (!got && cyc < 40) begin
            @(negedge clk);
            cyc++;
            bus_gnt = 1'b0;
            if (bus_req) begin
                bus_gnt  = 1'b1;
                bus_fill = {mem[{bus_addr[4:1], 1'b1}], mem[{bus_addr[4:1], 1'b0}]};
                case (bus_cmd)
                    2'd0: begin n_rd++; g_rda = bus_addr; end
                    2'd1: begin n_upd++; g_upa = bus_addr; g_upd = bus_wdata; end
                    default: begin n_wb++; g_wba = bus_addr; g_wbl = bus_line; end
                endcase
            end
            if (cpu_done) begin
                got = 1'b1; g_rdata = cpu_rdata; cpu_req = 1'b0;
            end
        end
        chk(got, "R10", "done seen", got, 1);
        @(negedge clk);
        bus_gnt = 1'b0;
        chk(cpu_done == 1'b0, "R10", "done one cycle", cpu_done, 0);
        chk(n_wb == int'(e_wb), "R8", "write-back count", n_wb, e_wb);
        if (e_wb) begin
            chk(g_wba == e_wba, "R8", "write-back addr", g_wba, e_wba);
            chk(g_wbl == e_wbl, "R8", "write-back line", g_wbl, e_wbl);
        end
        chk(n_rd == int'(!hit), rq, "read count", n_rd, !hit);
        if (!hit) chk(g_rda == {a[4:1], 1'b0}, "R2", "read addr", g_rda, {a[4:1], 1'b0});
        chk(n_upd == int'(e_upd), rq, "update count", n_upd, e_upd);
        if (e_upd) begin
            chk(g_upa == a, rq, "update addr", g_upa, a);
            chk(g_upd == wd, rq, "update word", g_upd, wd);
        end
        chk(g_rdata == e_rd, rq, "rdata", g_rdata, e_rd);
    endtask

    task automatic snoop(input logic cmd, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int t = a[4:3], i = a[2:1], o = a[0];
        bit hit = mp[i] && mtag[i] == t;
        bit sup = hit && !cmd && (mst[i] == SO || mst[i] == SD);
        logic [LW-1:0] e_l = {mdat[i][1], mdat[i][0]};
        string rq = hit ? (cmd ? "R6" : "R7") : "R9";
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; snp_wdata = wd;
        #1;
        chk(snp_copy == hit, rq, "snoop copy", snp_copy, hit);
        chk(snp_supply == sup, rq, "snoop supply", snp_supply, sup);
        if (sup) chk(snp_line == e_l, "R7", "supplied line", snp_line, e_l);
        if (hit && cmd) begin mdat[i][o] = wd; mst[i] = SH; end
        else if (hit) mst[i] = (mst[i] == SO || mst[i] == SD) ? SO : SH;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] lf = 16'hACE1;
        for (int a = 0; a < 32; a++) mem[a] = 8'(a * 7 + 3);
        for (int n = 0; n < NL; n++) begin mp[n] = 0; mst[n] = SC; mtag[n] = 0; end
        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0, "R1", "bus idle in reset", bus_req, 0);
        chk(cpu_done == 1'b0, "R1", "done low in reset", cpu_done, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            snp_valid = 1'b1; snp_cmd = a[0]; snp_addr = 5'(a);
            #1;
            chk(snp_copy == 1'b0, "R1", "nothing resident", snp_copy, 0);
        end
        @(negedge clk);
        snp_valid = 1'b0;
        for (int a = 0; a < 32; a++)
            for (int we = 0; we < 2; we++)
                for (int sh = 0; sh < 2; sh++)
                    for (int sc = 0; sc < 2; sc++) begin
                        cpu_op(we[0], 5'(a), 8'(a * 13 + sh), sh[0]);
                        snoop(sc[0], 5'(a), 8'(a * 5 + 1));
                        cpu_op(1'b1, 5'(a), 8'(a * 11 + we), sc[0] ^ sh[0]);
                    end
        for (int k = 0; k < 800; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[9:8] == 2'd0) snoop(lf[7], lf[4:0], lf[15:8]);
            else cpu_op(lf[7], lf[4:0], lf[15:8], lf[6]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule